// File: doc/BRIEF.md
# Nibble-Serial Handshaked Byte Transmitter

This block sends one byte across a four-bit handshaked bus as two nibbles, low nibble first. A byte arrives on a valid/ready input. A two-flip-flop phase machine then runs the transfer. In the drive phase the block asserts its own handshake line for a fixed delay with the nibble on the data lines. It then releases the line and waits for as long as the far end holds the synchronised handshake high. A gap phase follows, after which the upper nibble is driven the same way. After the second wait the machine returns to idle. The phase delays come from one counter. It counts only while the two phase flip-flops differ and restarts from zero on every phase change.

The bus byte is registered and carries the nibble on bits 7:6 and 1:0. The block's handshake is on bit 4 and the bus-available level on bit 2, both active low. Bits 5 and 3 are held released. A write-enable input gates the whole write path. While it is low the phase flip-flops and the counter are held at zero. A byte that has been accepted but not started stays pending until the enable returns.

Back-pressure rule: `s_ready` is the inverse of `wr_busy`. A byte is taken only on a cycle where `s_valid` and `s_ready` are both high. No second byte can be accepted until the previous transfer has returned to idle. `s_ready` does not depend on `s_valid`.

Top module: `nibble_link_tx`

## Requirements
- R1: `s_ready` equals the inverse of `wr_busy`. A cycle with `s_valid` and `s_ready` both high latches `s_data`, and `wr_busy` is high from the next cycle on.
- R2: With `hsk_sync` held low, `wr_busy` stays high for 3*DELAY+7 consecutive cycles after the accepting edge and is low afterwards.
- R3: With `wen` high, the bus shows the low nibble with bit 4 low (own handshake active) for DELAY+1 cycles. This starts on the third cycle after acceptance.
- R4: After a drive phase, bit 4 is released and the machine stays in the wait phase for as long as `hsk_sync` is high, however long that is.
- R5: After the first wait ends, the upper nibble is shown with bit 4 released for DELAY+1 gap cycles. The upper nibble is then shown with bit 4 low for DELAY+1 cycles.
- R6: When `hsk_sync` is low during the second wait, `wr_busy` drops on the next edge. The bus then returns to the low nibble with bit 4 released.
- R7: Bus format: bits 7:6 carry nibble bits 3:2 and bits 1:0 carry nibble bits 1:0. Bit 4 is the inverted own handshake and bit 2 is the inverted `bav_drive`. Bits 5 and 3 are 1. The register follows its inputs with one cycle of latency.
- R8: While `wen` is low the phase flip-flops and delay counter are zero and no handshake is driven. An accepted, unstarted byte stays pending (`wr_busy` high) and begins once `wen` rises. Dropping `wen` after the first phase has been entered abandons the byte.
- R9: The delay counter is zero whenever the two phase flip-flops are equal. It restarts on every phase change, so the gap after a long wait still lasts exactly DELAY+1 cycles.
- R10: After reset, `bus_out` is 8'h3C (with `bav_drive` low), `wr_busy` is 0 and `s_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| s_valid | input | 1 | Byte offered |
| s_ready | output | 1 | Byte can be taken (idle) |
| s_data | input | 8 | Byte to send |
| wen | input | 1 | Write path enable |
| bav_drive | input | 1 | Outgoing bus-available level, active high |
| hsk_sync | input | 1 | Synchronised remote handshake, high while far end holds |
| bus_out | output | 8 | Registered bus byte, control bits active low |
| wr_busy | output | 1 | Transfer pending or in progress |

## Verification
The closest same-cycle collision is a drop of `wen` in the very edge where the remote handshake releases the wait phase. One input wants to advance into the gap and the other forces the phases to zero. The bench parks the machine in the wait with `hsk_sync` high, then lowers both inputs at one falling edge. It expects `wr_busy` low after the next edge and no handshake or upper nibble ever to appear. A `bav_drive` change can also land on the same edge as a nibble change. The full sweep ties `bav_drive` to each byte's low bit and checks every bus bit on every cycle.

// File: rtl/nlt_pkg.sv
package nlt_pkg;

  localparam int NIB_W    = 4;
  localparam int BYTE_W   = 2 * NIB_W;
  localparam int POS_HSK  = 4;
  localparam int POS_BAV  = 2;
  localparam int POS_SP5  = 5;
  localparam int POS_SP3  = 3;

  // JK flip-flop next value (active-high J and K)
  function automatic logic jk_step(input logic q, input logic j, input logic k);
    logic r;
    case ({j, k})
      2'b00:   r = q;
      2'b01:   r = 1'b0;
      2'b10:   r = 1'b1;
      default: r = ~q;
    endcase
    return r;
  endfunction

  // Pack a nibble and the two active-low control levels into a bus byte
  function automatic logic [BYTE_W-1:0] bus_pack(input logic [NIB_W-1:0] nib,
                                                 input logic hsk_act,
                                                 input logic bav_act);
    logic [BYTE_W-1:0] v;
    v = '0;
    v[7:6]     = nib[3:2];
    v[1:0]     = nib[1:0];
    v[POS_HSK] = ~hsk_act;
    v[POS_BAV] = ~bav_act;
    v[POS_SP5] = 1'b1;
    v[POS_SP3] = 1'b1;
    return v;
  endfunction

endpackage

// File: rtl/nlt_load.sv
module nlt_load #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wen,
  input  logic          take,
  input  logic [DW-1:0] din,
  input  logic          ph_q1,
  output logic          pending,
  output logic          restart,
  output logic [DW-1:0] held
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= 1'b0;
      restart <= 1'b0;
      held    <= '0;
    end else begin
      if (take) begin
        pending <= 1'b1;
        held    <= din;
      end else if (ph_q1) begin
        pending <= 1'b0;
      end
      restart <= wen & pending;
    end
  end

endmodule

// File: rtl/nlt_delay.sv
module nlt_delay #(
  parameter int DELAY = 30,
  parameter int CW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wen,
  input  logic          run,
  input  logic          clr,
  output logic          tc,
  output logic [CW-1:0] cnt
);

  localparam logic [CW-1:0] TERM = CW'(DELAY);

  assign tc = (cnt == TERM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (!wen || !run || clr)
      cnt <= '0;
    else
      cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/nlt_phase.sv
module nlt_phase
  import nlt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wen,
  input  logic restart,
  input  logic tc,
  input  logic hsk_sync,
  output logic q1,
  output logic q2,
  output logic upper,
  output logic cont,
  output logic hsk_act
);

  logic j1, k1, j2, k2;
  logic q1_n, q2_n, upper_n;

  always_comb begin
    cont = (restart & ~q1 & ~q2)
         | (tc & (q1 ^ q2))
         | (hsk_sync & q1 & q2);
    j1 = cont & q2;
    k1 = (cont & ~q2) | (~cont & q2 & upper);
    j2 = cont;
    k2 = q1 & ~cont;
    q1_n = jk_step(q1, j1, k1);
    q2_n = jk_step(q2, j2, k2);
    if (!q1_n && !q2_n)
      upper_n = 1'b0;
    else if (q2 && !q2_n)
      upper_n = 1'b1;
    else
      upper_n = upper;
  end

  assign hsk_act = q2 & ~q1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q1    <= 1'b0;
      q2    <= 1'b0;
      upper <= 1'b0;
    end else if (!wen) begin
      q1    <= 1'b0;
      q2    <= 1'b0;
      upper <= 1'b0;
    end else begin
      q1    <= q1_n;
      q2    <= q2_n;
      upper <= upper_n;
    end
  end

endmodule

// File: rtl/nlt_bus.sv
module nlt_bus
  import nlt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] held,
  input  logic              upper,
  input  logic              hsk_act,
  input  logic              bav_drive,
  output logic [BYTE_W-1:0] bus_q
);

  localparam logic [BYTE_W-1:0] IDLE = bus_pack('0, 1'b0, 1'b0);

  logic [NIB_W-1:0]  nib;
  logic [BYTE_W-1:0] nxt_val;

  assign nib     = upper ? held[BYTE_W-1:NIB_W] : held[NIB_W-1:0];
  assign nxt_val = bus_pack(nib, hsk_act, bav_drive);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      bus_q <= IDLE;
    else if (nxt_val != bus_q)
      bus_q <= nxt_val;
  end

endmodule

// File: rtl/nibble_link_tx.sv
module nibble_link_tx #(
  parameter int DELAY = 30
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       s_valid,
  output logic       s_ready,
  input  logic [7:0] s_data,
  input  logic       wen,
  input  logic       bav_drive,
  input  logic       hsk_sync,
  output logic [7:0] bus_out,
  output logic       wr_busy
);

  localparam int CW = $clog2(DELAY + 1);

  logic          take;
  logic          pending, restart;
  logic [7:0]    held;
  logic          ph_q1, ph_q2, ph_upper, ph_cont, hsk_act;
  logic          dly_tc;
  logic [CW-1:0] dly_cnt;

  assign wr_busy = pending | ph_q1 | ph_q2;
  assign s_ready = ~wr_busy;
  assign take    = s_valid & s_ready;

  nlt_load #(.DW(8)) u_load (
    .clk(clk), .rst_n(rst_n), .wen(wen), .take(take), .din(s_data),
    .ph_q1(ph_q1), .pending(pending), .restart(restart), .held(held)
  );

  nlt_delay #(.DELAY(DELAY), .CW(CW)) u_delay (
    .clk(clk), .rst_n(rst_n), .wen(wen), .run(ph_q1 ^ ph_q2),
    .clr(ph_cont), .tc(dly_tc), .cnt(dly_cnt)
  );

  nlt_phase u_phase (
    .clk(clk), .rst_n(rst_n), .wen(wen), .restart(restart), .tc(dly_tc),
    .hsk_sync(hsk_sync), .q1(ph_q1), .q2(ph_q2), .upper(ph_upper),
    .cont(ph_cont), .hsk_act(hsk_act)
  );

  nlt_bus u_bus (
    .clk(clk), .rst_n(rst_n), .held(held), .upper(ph_upper),
    .hsk_act(hsk_act), .bav_drive(bav_drive), .bus_q(bus_out)
  );

endmodule

// File: rtl/nlt_checker.sv
module nlt_checker #(
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          s_valid,
  input logic          s_ready,
  input logic          wen,
  input logic          hsk_sync,
  input logic          wr_busy,
  input logic [7:0]    bus_out,
  input logic          ph_q1,
  input logic          ph_q2,
  input logic [CW-1:0] dly_cnt
);

  AST_BUSY_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> wr_busy); // R1

  AST_NO_READY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_busy |-> !s_ready); // R1

  AST_HSK_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_out[4] |-> $past(wr_busy)); // R3

  AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q1 && ph_q2 && hsk_sync && wen) |=> (ph_q1 && ph_q2)); // R4

  AST_NIB_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_out[4] && !$past(bus_out[4])) |->
      ($stable(bus_out[7:6]) && $stable(bus_out[1:0]))); // R7

  AST_WEN_OFF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !wen |=> (!ph_q1 && !ph_q2 && dly_cnt == '0)); // R8

  AST_CNT_EQUAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q1 == ph_q2) |-> (dly_cnt == '0)); // R9

endmodule

bind nibble_link_tx nlt_checker #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
  .wen(wen), .hsk_sync(hsk_sync), .wr_busy(wr_busy), .bus_out(bus_out),
  .ph_q1(ph_q1), .ph_q2(ph_q2), .dly_cnt(dly_cnt)
);

// File: tb/nibble_link_tx_bench.sv
`timescale 1ns/1ps
module nibble_link_tx_bench;

  localparam int D    = 30;
  localparam int TEND = 3 * D + 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       s_valid = 1'b0;
  logic       s_ready;
  logic [7:0] s_data = '0;
  logic       wen = 1'b1;
  logic       bav_drive = 1'b0;
  logic       hsk_sync = 1'b0;
  logic [7:0] bus_out;
  logic       wr_busy;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  nibble_link_tx #(.DELAY(D)) u_nibble_link_tx (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .wen(wen), .bav_drive(bav_drive), .hsk_sync(hsk_sync),
    .bus_out(bus_out), .wr_busy(wr_busy)
  );

  function automatic logic [7:0] enc(input logic [3:0] n, input logic hk, input logic bv);
    return {n[3:2], 1'b1, ~hk, 1'b1, ~bv, n[1:0]};
  endfunction

  task automatic check(input string req, input logic ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Offer a byte; returns at the falling edge right after the accepting edge
  task automatic offer(input logic [7:0] b, input logic bv);
    @(negedge clk);
    s_data = b; s_valid = 1'b1; bav_drive = bv;
    @(negedge clk);
    s_valid = 1'b0;
    check("R1 busy/ready after take", wr_busy === 1'b1 && s_ready === 1'b0,
          {wr_busy, s_ready}, 2'b10);
  endtask

  // Compare every cycle of a transfer against the arithmetic timeline
  task automatic track(input logic [7:0] b, input logic bv, input int t0);
    int bad = 0;
    string tag = "";
    int act = 0, expv = 0;
    for (int t = t0; t <= TEND; t++) begin
      int  s = t - 3;
      logic hi, hk, eb;
      logic [7:0] ev;
      hi = (s >= D + 2) && (s <= 3 * D + 4);
      hk = (s >= 0 && s <= D) || (s >= 2 * D + 3 && s <= 3 * D + 3);
      ev = enc(hi ? b[7:4] : b[3:0], hk, bv);
      eb = (t <= 3 * D + 6);
      if (bad == 0) begin
        if (wr_busy !== eb) begin
          bad = 1; tag = "R2"; act = wr_busy; expv = eb;
        end else if (bus_out !== ev) begin
          bad = 1; act = bus_out; expv = ev;
          if (s <= D + 1)          tag = "R3";
          else if (s <= 3 * D + 3) tag = "R5";
          else                     tag = "R6";
        end
      end
      if (t < TEND) @(negedge clk);
    end
    checks++;
    if (bad != 0) begin
      errors++;
      $display("FAIL %s byte %02h: actual %0h expected %0h", tag, b, act, expv);
    end
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check("R10 bus", bus_out === 8'h3C, bus_out, 8'h3C);
    check("R10 busy/ready", wr_busy === 1'b0 && s_ready === 1'b1, {wr_busy, s_ready}, 2'b01);

    // R7 bus-available level at idle, one cycle latency
    bav_drive = 1'b1;
    @(negedge clk);
    check("R7 bav bit", bus_out === enc(4'h0, 1'b0, 1'b1), bus_out, enc(4'h0, 1'b0, 1'b1));
    bav_drive = 1'b0;
    @(negedge clk);

    // Exhaustive byte sweep, bav tied to low data bit (R2 R3 R5 R6 R7)
    for (int b = 0; b < 256; b++) begin
      offer(8'(b), b[0]);
      @(negedge clk);
      track(8'(b), b[0], 1);
    end

    // R4 / R9: remote holds handshake
    hsk_sync = 1'b1;
    offer(8'hA5, 1'b0);
    repeat (150) @(negedge clk);
    check("R4 wait first", bus_out === enc(4'h5, 1'b0, 1'b0) && wr_busy === 1'b1,
          bus_out, enc(4'h5, 1'b0, 1'b0));
    hsk_sync = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R5 upper in gap", bus_out === enc(4'hA, 1'b0, 1'b0), bus_out, enc(4'hA, 1'b0, 1'b0));
    hsk_sync = 1'b1;
    repeat (D) @(negedge clk);
    check("R9 gap still released", bus_out[4] === 1'b1, bus_out[4], 1);
    @(negedge clk);
    check("R9 gap length", bus_out[4] === 1'b0, bus_out[4], 0);
    repeat (150) @(negedge clk);
    check("R4 wait second", bus_out === enc(4'hA, 1'b0, 1'b0) && wr_busy === 1'b1,
          bus_out, enc(4'hA, 1'b0, 1'b0));
    hsk_sync = 1'b0;
    @(negedge clk);
    check("R6 busy drops", wr_busy === 1'b0, wr_busy, 0);
    @(negedge clk);
    check("R6 bus idle", bus_out === enc(4'h5, 1'b0, 1'b0), bus_out, enc(4'h5, 1'b0, 1'b0));

    // R8: enable drop in the same cycle as the wait releases
    hsk_sync = 1'b1;
    offer(8'h3C, 1'b0);
    repeat (150) @(negedge clk);
    hsk_sync = 1'b0; wen = 1'b0;
    @(negedge clk);
    check("R8 abort busy", wr_busy === 1'b0, wr_busy, 0);
    begin
      int bad = 0;
      for (int i = 0; i < 100; i++) begin
        @(negedge clk);
        if (bus_out !== enc(4'hC, 1'b0, 1'b0)) bad++;
      end
      check("R8 abort quiet", bad == 0, bus_out, enc(4'hC, 1'b0, 1'b0));
      wen = 1'b1;
      bad = 0;
      for (int i = 0; i < 60; i++) begin
        @(negedge clk);
        if (bus_out !== enc(4'hC, 1'b0, 1'b0) || wr_busy !== 1'b0) bad++;
      end
      check("R8 no restart", bad == 0, bus_out, enc(4'hC, 1'b0, 1'b0));

      // R8: byte loaded with enable off stays pending, then runs
      wen = 1'b0;
      offer(8'h96, 1'b1);
      bad = 0;
      for (int i = 0; i < 100; i++) begin
        @(negedge clk);
        if (bus_out !== enc(4'h6, 1'b0, 1'b1) || wr_busy !== 1'b1) bad++;
      end
      check("R8 pending held", bad == 0, bus_out, enc(4'h6, 1'b0, 1'b1));
    end
    wen = 1'b1;
    @(negedge clk);
    track(8'h96, 1'b1, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule